// File: doc/BRIEF.md
# Instruction/Data Shared Memory Bus Arbiter

This block lets a processor that has two separate master ports, one for instruction fetch and one for data access, reach memory through a single external bus. Because only one bus leaves the block, the processor needs fewer device pins. A small state machine gives the external bus to exactly one port at a time. It forwards that port's address, write data, byte enables and direction, and it returns read data, acknowledges and error responses to that port alone.

Every access runs as a cache-line burst of `BEATS` words. The block generates each beat address from the requester's base address, and it flags the final beat on the bus. A data access can also be marked as a single word, which then runs as a one-beat burst. When both ports ask in the same idle cycle, the data port wins. An instruction fetch simply waits, which is acceptable for an in-order core. A burst is never interrupted by the other port. When a burst ends and the other port is waiting, the bus passes to it directly, with no idle cycle between the two bursts.

A requester raises its request and holds its address and controls steady until it has seen its final acknowledge or an error. When a burst completes, the finishing port's own request is not considered again, so the same request is not granted twice. A master that wants two bursts in a row lowers its request for one cycle between them.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no request present, `m_stb` and `m_we` are low and neither port sees an acknowledge. This holds even when a request is held high during reset.
- R2: When the bus is idle and both `d_req` and `i_req` are high in the same cycle, the data port is served first. The instruction port's first beat comes only after the data burst has ended.
- R3: Once a port owns the bus, it keeps the bus until its last beat is acknowledged or an error ends the burst. A request from the other port that arrives mid-burst does not interrupt it, and `m_addr` and `m_we` stay steady while a beat waits for its response.
- R4: A burst is `BEATS` beats long (4 by default). Beat j of a burst starting at base address A is driven at address A + 4*j, and `m_last` is high on the final beat only.
- R5: A data access with `d_burst` = 0 runs as a single beat, and `m_last` is high on that first beat.
- R6: `m_ack`, `m_err` and `m_rdata` are routed only to the owning port. The port that does not own the bus sees its acknowledge and error low, and both ports are never acknowledged in the same cycle.
- R7: While the data port owns the bus, `m_we`, `m_wdata` and `m_be` follow `d_we`, `d_wdata` and `d_be`, where `m_be` bit k enables byte k (bits 8k+7..8k). Instruction bursts are reads with every byte enable high.
- R8: When a burst completes while the other port is requesting, the other port's burst starts in the very next cycle, so `m_stb` stays high across the handoff. The finishing port's own request is not re-granted at that point.
- R9: An error response on `m_err` is passed to the owning port as its error signal and ends the burst at once. The bus then returns to idle, or passes directly to the other port if that port is requesting.
- R10: An instruction request that loses to a data request stays pending and is served as soon as the data burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_req | input | 1 | Data port request, held until final acknowledge or error |
| d_we | input | 1 | Data port write (1) or read (0) |
| d_burst | input | 1 | Data access is a full line burst (1) or a single word (0) |
| d_addr | input | AW | Data port base byte address |
| d_wdata | input | DW | Data port write data for the current beat |
| d_be | input | DW/8 | Data port byte enables |
| d_rdata | output | DW | Read data returned to the data port |
| d_ack | output | 1 | Per-beat acknowledge to the data port |
| d_err | output | 1 | Error response to the data port |
| i_req | input | 1 | Instruction fetch request, held until final acknowledge or error |
| i_addr | input | AW | Instruction fetch base byte address |
| i_rdata | output | DW | Read data returned to the instruction port |
| i_ack | output | 1 | Per-beat acknowledge to the instruction port |
| i_err | output | 1 | Error response to the instruction port |
| m_stb | output | 1 | External bus beat valid / bus owned |
| m_we | output | 1 | External write enable |
| m_last | output | 1 | Current beat is the final beat of the burst |
| m_addr | output | AW | External beat address |
| m_wdata | output | DW | External write data |
| m_be | output | DW/8 | External byte enables |
| m_rdata | input | DW | External read data |
| m_ack | input | 1 | External beat acknowledge |
| m_err | input | 1 | External error response |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the two ports asking for an idle bus together. The second is one burst's final acknowledge, or an error, arriving while the other port is already waiting. The bench raises both requests in the same cycle, and in other cases raises a data request part-way through an instruction burst or places an error on a chosen beat. A memory model with a per-vector wait count delivers the responses. The order in which beats reach each port is then compared with the expected order: data first for a tie, instruction first when the data request came late. Across every handoff `m_stb` must never drop while a request is pending.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

   // Which master currently owns the shared bus.
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_DATA  = 2'd1,
      OWN_INSTR = 2'd2
   } own_state_e;

endpackage

// File: rtl/arb_fsm.sv
`timescale 1ns/1ps
module arb_fsm
   import arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       d_req,
   input  logic       i_req,
   input  logic       burst_end,
   output own_state_e state,
   output logic       own_d,
   output logic       own_i
);

   own_state_e state_q, state_d;

   // Ownership changes only while idle or on the cycle a burst ends.
   // On a burst end only the other port is considered.
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         OWN_NONE: begin
            if (d_req)      state_d = OWN_DATA;
            else if (i_req) state_d = OWN_INSTR;
         end
         OWN_DATA: begin
            if (burst_end)  state_d = i_req ? OWN_INSTR : OWN_NONE;
         end
         OWN_INSTR: begin
            if (burst_end)  state_d = d_req ? OWN_DATA : OWN_NONE;
         end
         default:           state_d = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= OWN_NONE;
      else        state_q <= state_d;
   end

   assign state = state_q;
   assign own_d = (state_q == OWN_DATA);
   assign own_i = (state_q == OWN_INSTR);

endmodule

// File: rtl/arb_beat_gen.sv
`timescale 1ns/1ps
module arb_beat_gen #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4,
   parameter bit WRAP  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack,
   input  logic          burst_end,
   input  logic          single,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] beat_addr,
   output logic          last
);

   localparam int BW      = DW / 8;
   localparam int BSH     = $clog2(BW);
   localparam int CW      = $clog2(BEATS);
   localparam int LINE_SH = BSH + CW;

   logic [CW-1:0] cnt_q;

   // Beat index: cleared when a burst ends, advanced on each acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (burst_end) cnt_q <= '0;
      else if (ack)       cnt_q <= cnt_q + 1'b1;
   end

   assign last = single | (cnt_q == CW'(BEATS - 1));

   generate
      if (WRAP) begin : g_wrap
         // Beat index replaces the word-in-line field; the line stays fixed.
         logic [CW-1:0] word_in_line;
         assign word_in_line = base[LINE_SH-1:BSH] + cnt_q;
         assign beat_addr    = {base[AW-1:LINE_SH], word_in_line, base[BSH-1:0]};
      end else begin : g_incr
         // Plain incrementing address, one word per beat.
         logic [AW-1:0] offs;
         assign offs      = {{(AW - CW){1'b0}}, cnt_q} << BSH;
         assign beat_addr = base + offs;
      end
   endgenerate

endmodule

// File: rtl/arb_route.sv
`timescale 1ns/1ps
module arb_route #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic            own_d,
   input  logic            own_i,
   input  logic [AW-1:0]   d_addr,
   input  logic            d_we,
   input  logic [DW-1:0]   d_wdata,
   input  logic [DW/8-1:0] d_be,
   input  logic [AW-1:0]   i_addr,
   input  logic [DW-1:0]   m_rdata,
   input  logic            m_ack,
   input  logic            m_err,
   output logic [AW-1:0]   base_addr,
   output logic            m_we,
   output logic [DW-1:0]   m_wdata,
   output logic [DW/8-1:0] m_be,
   output logic [DW-1:0]   d_rdata,
   output logic            d_ack,
   output logic            d_err,
   output logic [DW-1:0]   i_rdata,
   output logic            i_ack,
   output logic            i_err
);

   localparam int BW = DW / 8;

   // Request side: the owner's controls go out; the rest is held quiet.
   always_comb begin
      base_addr = '0;
      m_we      = 1'b0;
      m_wdata   = '0;
      m_be      = '0;
      if (own_d) begin
         base_addr = d_addr;
         m_we      = d_we;
         m_wdata   = d_wdata;
         m_be      = d_be;
      end else if (own_i) begin
         base_addr = i_addr;
         m_be      = {BW{1'b1}};
      end
   end

   // Response side: only the owner is told about the bus response.
   assign d_ack   = own_d & m_ack & ~m_err;
   assign d_err   = own_d & m_err;
   assign d_rdata = own_d ? m_rdata : '0;
   assign i_ack   = own_i & m_ack & ~m_err;
   assign i_err   = own_i & m_err;
   assign i_rdata = own_i ? m_rdata : '0;

endmodule

// File: rtl/shared_bus_arbiter.sv
`timescale 1ns/1ps
module shared_bus_arbiter
   import arb_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4,
   parameter bit WRAP  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            d_req,
   input  logic            d_we,
   input  logic            d_burst,
   input  logic [AW-1:0]   d_addr,
   input  logic [DW-1:0]   d_wdata,
   input  logic [DW/8-1:0] d_be,
   output logic [DW-1:0]   d_rdata,
   output logic            d_ack,
   output logic            d_err,
   input  logic            i_req,
   input  logic [AW-1:0]   i_addr,
   output logic [DW-1:0]   i_rdata,
   output logic            i_ack,
   output logic            i_err,
   output logic            m_stb,
   output logic            m_we,
   output logic            m_last,
   output logic [AW-1:0]   m_addr,
   output logic [DW-1:0]   m_wdata,
   output logic [DW/8-1:0] m_be,
   input  logic [DW-1:0]   m_rdata,
   input  logic            m_ack,
   input  logic            m_err
);

   localparam int BW = DW / 8;

   generate
      if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
         $error("BEATS must be a power of two of at least 2");
      end
      if (DW < 16 || (DW % 8) != 0 || (BW & (BW - 1)) != 0) begin : g_bad_dw
         $error("DW must be a power-of-two byte multiple of at least 16");
      end
      if (AW <= $clog2(BW) + $clog2(BEATS)) begin : g_bad_aw
         $error("AW too narrow for one cache line");
      end
   endgenerate

   own_state_e      state;
   logic            own_d, own_i;
   logic            burst_end;
   logic            last;
   logic            single;
   logic [AW-1:0]   base_addr;
   logic [AW-1:0]   beat_addr;

   assign m_stb     = own_d | own_i;
   assign single    = own_d & ~d_burst;
   assign burst_end = m_stb & (m_err | (m_ack & last));
   assign m_last    = m_stb & last;
   assign m_addr    = m_stb ? beat_addr : '0;

   arb_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .d_req     (d_req),
      .i_req     (i_req),
      .burst_end (burst_end),
      .state     (state),
      .own_d     (own_d),
      .own_i     (own_i)
   );

   arb_beat_gen #(
      .AW    (AW),
      .DW    (DW),
      .BEATS (BEATS),
      .WRAP  (WRAP)
   ) i_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack       (m_stb & m_ack),
      .burst_end (burst_end),
      .single    (single),
      .base      (base_addr),
      .beat_addr (beat_addr),
      .last      (last)
   );

   arb_route #(
      .AW (AW),
      .DW (DW)
   ) i_route (
      .own_d     (own_d),
      .own_i     (own_i),
      .d_addr    (d_addr),
      .d_we      (d_we),
      .d_wdata   (d_wdata),
      .d_be      (d_be),
      .i_addr    (i_addr),
      .m_rdata   (m_rdata),
      .m_ack     (m_ack),
      .m_err     (m_err),
      .base_addr (base_addr),
      .m_we      (m_we),
      .m_wdata   (m_wdata),
      .m_be      (m_be),
      .d_rdata   (d_rdata),
      .d_ack     (d_ack),
      .d_err     (d_err),
      .i_rdata   (i_rdata),
      .i_ack     (i_ack),
      .i_err     (i_err)
   );

endmodule

// File: rtl/arb_checks.sv
`timescale 1ns/1ps
module arb_checks #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          d_req,
   input logic          i_req,
   input logic          d_ack,
   input logic          d_err,
   input logic          i_ack,
   input logic          i_err,
   input logic          m_stb,
   input logic          m_we,
   input logic          m_last,
   input logic [AW-1:0] m_addr,
   input logic          m_ack,
   input logic          m_err,
   input logic          own_d,
   input logic          own_i
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!m_stb && !m_we && !d_ack && !i_ack));

   // R2
   data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_stb && d_req) |=> own_d);

   // R3
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_stb && !m_ack && !m_err) |=> (m_stb && $stable(m_addr) && $stable(m_we)));

   // R3
   no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_stb && m_ack && !m_last && !m_err) |=> (m_stb && $stable(own_d)));

   // R6
   dual_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((d_ack || d_err) && (i_ack || i_err)));

   // R6
   loser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_d |-> (!i_ack && !i_err)) and (own_i |-> (!d_ack && !d_err)));

   // R8
   handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_d && m_ack && m_last && i_req) |=> own_i);

   // R9
   err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_i && m_err && !d_req) |=> !m_stb);

endmodule

bind shared_bus_arbiter arb_checks #(.AW(AW)) i_arb_checks (
   .clk    (clk),
   .rst_n  (rst_n),
   .d_req  (d_req),
   .i_req  (i_req),
   .d_ack  (d_ack),
   .d_err  (d_err),
   .i_ack  (i_ack),
   .i_err  (i_err),
   .m_stb  (m_stb),
   .m_we   (m_we),
   .m_last (m_last),
   .m_addr (m_addr),
   .m_ack  (m_ack),
   .m_err  (m_err),
   .own_d  (own_d),
   .own_i  (own_i)
);

// File: tb/test_shared_bus_arbiter.sv
`timescale 1ns/1ps
module test_shared_bus_arbiter;

   localparam int AW = 32;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n;
   always #2.5 clk = ~clk;

   logic          d_req = 0, d_we = 0, d_burst = 0;
   logic [AW-1:0] d_addr = 0;
   logic [DW-1:0] d_wdata = 0;
   logic [3:0]    d_be = 0;
   logic [DW-1:0] d_rdata;
   logic          d_ack, d_err;
   logic          i_req = 0;
   logic [AW-1:0] i_addr = 0;
   logic [DW-1:0] i_rdata;
   logic          i_ack, i_err;
   logic          m_stb, m_we, m_last;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata;
   logic [3:0]    m_be;
   logic [DW-1:0] m_rdata = 0;
   logic          m_ack = 0, m_err = 0;

   shared_bus_arbiter #(.AW(AW), .DW(DW)) i_shared_bus_arbiter (
      .clk(clk), .rst_n(rst_n),
      .d_req(d_req), .d_we(d_we), .d_burst(d_burst), .d_addr(d_addr),
      .d_wdata(d_wdata), .d_be(d_be), .d_rdata(d_rdata), .d_ack(d_ack), .d_err(d_err),
      .i_req(i_req), .i_addr(i_addr), .i_rdata(i_rdata), .i_ack(i_ack), .i_err(i_err),
      .m_stb(m_stb), .m_we(m_we), .m_last(m_last), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_be(m_be), .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] wpat(input int w);
      return 32'hC0DE_0000 | w;
   endfunction

   // ---------------- memory model ----------------
   logic [31:0] mem  [64];
   logic [31:0] expm [64];
   int lat = 0;
   int wcnt = 0;
   int err_word = -1;

   always @(negedge clk) begin
      m_ack = 1'b0;
      m_err = 1'b0;
      if (m_stb) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            if (int'(m_addr[7:2]) == err_word) begin
               m_err = 1'b1;
            end else begin
               m_ack   = 1'b1;
               m_rdata = mem[m_addr[7:2]];
               if (m_we)
                  for (int b = 0; b < 4; b++)
                     if (m_be[b]) mem[m_addr[7:2]][8*b +: 8] = m_wdata[8*b +: 8];
            end
         end else begin
            wcnt++;
         end
      end else begin
         wcnt = 0;
      end
   end

   // ---------------- masters and monitor ----------------
   int d_len = 0, d_widx = 0, d_n = 0, d_lastpos = -1, d_errs = 0;
   int i_len = 4, i_n = 0, i_lastpos = -1, i_errs = 0;
   logic [31:0] d_rd [4], i_rd [4];
   logic [31:0] d_ad [4], i_ad [4];
   int first_port = 0, last_port = 0, switches = 0, gaps = 0, misroute = 0, bad_wr = 0;
   bit seen_stb = 0;

   always @(negedge clk) begin
      #1;
      if (m_stb) seen_stb = 1;
      else if (seen_stb && (d_req || i_req)) gaps++;
      if (m_ack || m_err) begin
         int p;
         p = (d_ack || d_err) ? 1 : ((i_ack || i_err) ? 2 : 0);
         if (p == 0) misroute++;
         if ((d_ack || d_err) && (i_ack || i_err)) misroute++;
         if (last_port != 0 && p != last_port) switches++;
         last_port = p;
         if (first_port == 0) first_port = p;
      end
      if (d_ack && d_n < 4) begin
         d_rd[d_n] = d_rdata;
         d_ad[d_n] = m_addr;
         if (m_last) d_lastpos = d_n;
         if (m_we !== d_we || m_be !== d_be || (d_we && m_wdata !== d_wdata)) bad_wr++;
         d_n++;
      end
      if (d_err) d_errs++;
      if (i_ack && i_n < 4) begin
         i_rd[i_n] = i_rdata;
         i_ad[i_n] = m_addr;
         if (m_last) i_lastpos = i_n;
         if (m_we !== 1'b0 || m_be !== 4'hF) bad_wr++;
         i_n++;
      end
      if (i_err) i_errs++;
      d_wdata = wpat(d_widx + d_n);
      if (d_req && (d_n >= d_len || d_errs != 0)) d_req = 1'b0;
      if (i_req && (i_n >= i_len || i_errs != 0)) i_req = 1'b0;
   end

   task automatic clear_mon();
      d_n = 0; d_lastpos = -1; d_errs = 0;
      i_n = 0; i_lastpos = -1; i_errs = 0;
      first_port = 0; last_port = 0; switches = 0; gaps = 0;
      misroute = 0; bad_wr = 0; seen_stb = 0;
   endtask

   task automatic start_d(input int w, input bit bst, input bit wr, input logic [3:0] be);
      d_addr = AW'(w * 4); d_we = wr; d_burst = bst; d_be = be;
      d_widx = w; d_wdata = wpat(w); d_len = bst ? 4 : 1;
      d_req = 1'b1;
   endtask

   task automatic start_i(input int w);
      i_addr = AW'(w * 4);
      i_req = 1'b1;
   endtask

   task automatic wait_done(input string tag);
      int k;
      k = 0;
      while ((d_req || i_req) && k < 1000) begin
         @(negedge clk);
         k++;
      end
      chk(!(d_req || i_req), tag, k, 0);
      repeat (3) @(negedge clk);
      #1.5;
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      logic       use_d;
      logic       d_bst;
      logic       d_wr;
      logic [3:0] d_be;
      logic [5:0] d_w;
      logic       use_i;
      logic [5:0] i_w;
      logic [1:0] lt;
      logic       d_late;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b1, 1'b0, 4'hF, 6'd4,  1'b0, 6'd0,  2'd0, 1'b0},
      '{1'b0, 1'b1, 1'b0, 4'hF, 6'd0,  1'b1, 6'd8,  2'd1, 1'b0},
      '{1'b1, 1'b1, 1'b0, 4'hF, 6'd12, 1'b1, 6'd16, 2'd0, 1'b0},
      '{1'b1, 1'b1, 1'b1, 4'hF, 6'd20, 1'b1, 6'd24, 2'd2, 1'b0},
      '{1'b1, 1'b1, 1'b0, 4'hF, 6'd28, 1'b1, 6'd20, 2'd1, 1'b1},
      '{1'b1, 1'b0, 1'b1, 4'h5, 6'd33, 1'b0, 6'd0,  2'd0, 1'b0},
      '{1'b1, 1'b0, 1'b0, 4'hF, 6'd33, 1'b1, 6'd36, 2'd3, 1'b0}
   };

   task automatic run_vec(input vec_t v, input int idx);
      int dl;
      dl = v.d_bst ? 4 : 1;
      lat = int'(v.lt);
      @(negedge clk); #1.5;
      clear_mon();
      if (v.d_late) begin
         start_i(int'(v.i_w));
         repeat (2) @(negedge clk);
         #1.5;
         start_d(int'(v.d_w), v.d_bst, v.d_wr, v.d_be);
      end else begin
         if (v.use_d) start_d(int'(v.d_w), v.d_bst, v.d_wr, v.d_be);
         if (v.use_i) start_i(int'(v.i_w));
      end
      wait_done($sformatf("R3 vec%0d completion", idx));
      if (v.use_d) begin
         string tg;
         tg = v.d_bst ? "R4" : "R5";
         chk(d_n == dl, $sformatf("%s vec%0d data beats", tg, idx), d_n, dl);
         chk(d_lastpos == dl - 1, $sformatf("%s vec%0d data last beat", tg, idx), d_lastpos, dl - 1);
         for (int j = 0; j < dl; j++) begin
            chk(d_ad[j] == 32'((int'(v.d_w) + j) * 4), $sformatf("R4 vec%0d data addr%0d", idx, j),
                d_ad[j], (int'(v.d_w) + j) * 4);
            if (!v.d_wr)
               chk(d_rd[j] == expm[int'(v.d_w) + j], $sformatf("R6 vec%0d data rdata%0d", idx, j),
                   d_rd[j], expm[int'(v.d_w) + j]);
         end
      end
      if (v.use_i) begin
         chk(i_n == 4, $sformatf("R4 vec%0d instr beats", idx), i_n, 4);
         chk(i_lastpos == 3, $sformatf("R4 vec%0d instr last beat", idx), i_lastpos, 3);
         for (int j = 0; j < 4; j++) begin
            chk(i_ad[j] == 32'((int'(v.i_w) + j) * 4), $sformatf("R4 vec%0d instr addr%0d", idx, j),
                i_ad[j], (int'(v.i_w) + j) * 4);
            chk(i_rd[j] == expm[int'(v.i_w) + j], $sformatf("R6 vec%0d instr rdata%0d", idx, j),
                i_rd[j], expm[int'(v.i_w) + j]);
         end
      end
      chk(bad_wr == 0, $sformatf("R7 vec%0d forwarded controls", idx), bad_wr, 0);
      chk(misroute == 0, $sformatf("R6 vec%0d response routing", idx), misroute, 0);
      chk(gaps == 0, $sformatf("R8 vec%0d idle gaps with request pending", idx), gaps, 0);
      if (v.use_d && v.use_i) begin
         if (v.d_late)
            chk(first_port == 2, $sformatf("R3 vec%0d instr not preempted", idx), first_port, 2);
         else
            chk(first_port == 1, $sformatf("R2 vec%0d data served first", idx), first_port, 1);
         chk(switches == 1, $sformatf("R10 vec%0d pending port served after owner", idx), switches, 1);
      end
      if (v.use_d && v.d_wr)
         for (int j = 0; j < dl; j++)
            for (int b = 0; b < 4; b++)
               if (v.d_be[b]) expm[int'(v.d_w) + j][8*b +: 8] = wpat(int'(v.d_w) + j) >> (8*b);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      for (int k = 0; k < 64; k++) begin
         mem[k]  = 32'h1000_0000 + k * 32'h0101;
         expm[k] = 32'h1000_0000 + k * 32'h0101;
      end
      rst_n = 1'b0;
      d_req = 1'b1;
      repeat (3) @(negedge clk);
      #1.5;
      // R1: request held during reset gets no grant
      chk(m_stb == 1'b0, "R1 m_stb low in reset", m_stb, 0);
      chk(m_we == 1'b0, "R1 m_we low in reset", m_we, 0);
      chk(d_ack == 1'b0 && i_ack == 1'b0, "R1 no ack in reset", {d_ack, i_ack}, 0);
      d_req = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1.5;
      chk(m_stb == 1'b0, "R1 idle after reset", m_stb, 0);

      for (int v = 0; v < NV; v++) run_vec(VECS[v], v);

      // R9: error on beat 1 of a data burst with instruction waiting
      @(negedge clk); #1.5;
      clear_mon();
      lat = 0; err_word = 41;
      start_d(40, 1'b1, 1'b0, 4'hF);
      start_i(44);
      wait_done("R9 error burst completion");
      chk(d_n == 1, "R9 data beats before error", d_n, 1);
      chk(d_errs == 1, "R9 error forwarded to data port", d_errs, 1);
      chk(i_errs == 0, "R6 error not shown to instr port", i_errs, 0);
      chk(i_n == 4, "R9 instr served after error", i_n, 4);
      chk(gaps == 0, "R8 handoff after error without idle", gaps, 0);

      // R9: error inside an instruction burst returns the bus to idle
      clear_mon();
      lat = 1; err_word = 50;
      start_i(48);
      begin
         int k;
         k = 0;
         while (i_req && k < 1000) begin
            @(negedge clk);
            k++;
         end
      end
      @(negedge clk); #1.5;
      chk(m_stb == 1'b0, "R9 idle after instr error", m_stb, 0);
      chk(i_n == 2, "R9 instr beats before error", i_n, 2);
      chk(i_errs == 1, "R9 error forwarded to instr port", i_errs, 1);
      chk(d_errs == 0, "R6 error not shown to data port", d_errs, 0);
      err_word = -1;
      repeat (3) @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule